// File: doc/BRIEF.md
# Branch Way-Pointer Table with Global Clear

This block sits beside a branch target buffer and gives each of its entries a memory of which cache way held the instructions fetched after the branch. A 4-way set-associative instruction cache can read these recorded way pointers when the buffer hits. It then powers only the data way it needs and skips the tag compare for the accesses that follow the branch. Each entry keeps two independent groups, one for the taken outcome and one for the not-taken outcome. Each group has a valid flag and `NPTR` pointers of 2 bits, ordered by sequential access after the branch.

A lookup is presented when the branch target buffer hits. The low address bits above the alignment bits pick the entry, and the predicted direction picks the group. The group comes back one cycle later. A recording unit outside the block fills a group one pointer at a time and then commits it through the write port. The write carries the branch address and direction that the recording unit saved, and a count of the pointers it captured. When a cache refill may have moved lines, a global clear drops every valid flag at once. Each commit and each clear takes the table away from lookups for one cycle, and the block signals that cycle on `stall`.

The controller has three states. `ST_SERVE` accepts lookups. `ST_FLUSH` clears all flags. `ST_COMMIT` writes the saved group. From every state, the transition `GO_FLUSH` is taken when a clear is requested. `GO_COMMIT` is taken when a write is requested without a clear. `GO_SERVE` is taken when neither is requested.

Top module: `wpt_table`

## Requirements
- R1: After reset every group of every entry reads as invalid, and `stall` and `rsp_valid` are low.
- R2: A lookup accepted in cycle t (`lk_req` high, `stall` low) raises `rsp_valid` in cycle t+1 with the group of entry `lk_addr[5:2]` for direction `lk_dir` (1 = taken, 0 = not taken). `rsp_valid` is low after a cycle with no accepted lookup.
- R3: A write requested in cycle t makes `stall` high in cycle t+1 only. From cycle t+2 a lookup of that entry and direction returns the written pointers, with pointer k in bits [2k+1:2k], and valid set when `wr_count` equals `NPTR`.
- R4: A write whose `wr_count` is below `NPTR` leaves that group invalid.
- R5: A clear requested in cycle t makes `stall` high in cycle t+1 only. From cycle t+2 every group reads as invalid.
- R6: When a clear and a write are requested in the same cycle, only the clear happens. The write is dropped and the group stays invalid.
- R7: A lookup presented while `stall` is high gets no response: `rsp_valid` is low in the next cycle.
- R8: The taken and not-taken groups of one entry are independent. Writing one leaves the other unchanged.
- R9: A write uses the address, direction, count and pointers sampled in its request cycle. Changes to the write inputs or to the lookup address during the stall cycle do not redirect it. Address bits above bit 5 do not affect which entry is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req | input | 1 | Lookup request on a branch target buffer hit |
| lk_addr | input | ADDR_W | Branch address of the lookup |
| lk_dir | input | 1 | Predicted direction, 1 = taken |
| wr_req | input | 1 | Commit a recorded group |
| wr_addr | input | ADDR_W | Saved branch address of the recorded group |
| wr_dir | input | 1 | Saved direction of the recorded group |
| wr_count | input | CNT_W | Number of pointers captured |
| wr_ptrs | input | 2*NPTR | Recorded pointers, pointer k in bits [2k+1:2k] |
| inv_req | input | 1 | Clear every valid flag |
| stall | output | 1 | Table busy; lookups are not accepted |
| rsp_valid | output | 1 | Lookup response present |
| rsp_grp_valid | output | 1 | Returned group is valid |
| rsp_ptrs | output | 2*NPTR | Returned pointers |

## Verification
A lookup result is due one cycle after the request edge. The bench drives on the falling edge and reads the response at the next falling edge, after exactly one rising edge. A commit or a clear shows `stall` at the first falling edge after the request. The bench checks the table contents only after the second rising edge, when the array has been updated. It then probes the table with ordinary lookups. Lookups and changes to the write inputs made inside the stall cycle are judged at the falling edge that follows it.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
    localparam int WAY_PTR_W = 2;

    typedef enum logic [1:0] {
        ST_SERVE  = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_COMMIT = 2'd2
    } wpt_state_e;
endpackage

// File: rtl/wpt_ctrl.sv
module wpt_ctrl
    import wpt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 4,
    parameter int NPTR    = 4,
    parameter int CNT_W   = 3,
    parameter int GRP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_dir,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic [GRP_W-1:0]  wr_ptrs,
    output logic              stall,
    output logic              flush_en,
    output logic              commit_en,
    output logic [IDX_W-1:0]  commit_idx,
    output logic              commit_dir,
    output logic              commit_full,
    output logic [GRP_W-1:0]  commit_ptrs
);
    wpt_state_e state_q, state_d;

    // next state: GO_FLUSH beats GO_COMMIT, otherwise GO_SERVE
    always_comb begin
        if (inv_req)     state_d = ST_FLUSH;
        else if (wr_req) state_d = ST_COMMIT;
        else             state_d = ST_SERVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SERVE;
        else        state_q <= state_d;
    end

    // saved write fields, taken only in the request cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_idx  <= '0;
            commit_dir  <= 1'b0;
            commit_full <= 1'b0;
            commit_ptrs <= '0;
        end else if (wr_req && !inv_req) begin
            commit_idx  <= wr_addr[ALIGN_W +: IDX_W];
            commit_dir  <= wr_dir;
            commit_full <= (wr_count == CNT_W'(NPTR));
            commit_ptrs <= wr_ptrs;
        end
    end

    always_comb begin
        stall     = 1'b0;
        flush_en  = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            ST_SERVE:  ;
            ST_FLUSH:  begin stall = 1'b1; flush_en  = 1'b1; end
            ST_COMMIT: begin stall = 1'b1; commit_en = 1'b1; end
            default:   stall = 1'b1;
        endcase
    end

    // a stall cycle always follows a request (R3/R5)
    p_stall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(inv_req || wr_req));
    // no request means no stall next cycle: stall is exactly one cycle (R5)
    p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_req && !wr_req) |=> !stall);
    // a joint request never reaches the commit state (R6)
    p_flush_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && wr_req) |=> (flush_en && !commit_en));
endmodule

// File: rtl/wpt_store.sv
module wpt_store #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int GRP_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_en,
    input  logic             commit_en,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic             commit_dir,
    input  logic             commit_full,
    input  logic [GRP_W-1:0] commit_ptrs,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_dir,
    output logic             rd_valid,
    output logic [GRP_W-1:0] rd_ptrs
);
    localparam int SLOTS  = 2 * ENTRIES;
    localparam int SLOT_W = IDX_W + 1;

    logic [SLOTS-1:0] vld_q;
    logic [GRP_W-1:0] ptr_q [SLOTS];
    logic [SLOT_W-1:0] w_slot, r_slot;

    assign w_slot = {commit_dir, commit_idx};
    assign r_slot = {rd_dir, rd_idx};

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vld_q[s] <= 1'b0;
            else if (flush_en)
                vld_q[s] <= 1'b0;
            else if (commit_en && (w_slot == SLOT_W'(s)))
                vld_q[s] <= commit_full;
        end

        always_ff @(posedge clk) begin
            if (commit_en && (w_slot == SLOT_W'(s)))
                ptr_q[s] <= commit_ptrs;
        end
    end

    assign rd_valid = vld_q[r_slot];
    assign rd_ptrs  = ptr_q[r_slot];

    p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (vld_q == '0));
    p_partial_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !commit_full) |=> !vld_q[$past(w_slot)]);
endmodule

// File: rtl/wpt_rsp.sv
module wpt_rsp #(
    parameter int GRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             grp_valid,
    input  logic [GRP_W-1:0] grp_ptrs,
    output logic             rsp_valid,
    output logic             rsp_grp_valid,
    output logic [GRP_W-1:0] rsp_ptrs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_grp_valid <= 1'b0;
            rsp_ptrs      <= '0;
        end else begin
            rsp_valid <= take;
            if (take) begin
                rsp_grp_valid <= grp_valid;
                rsp_ptrs      <= grp_ptrs;
            end
        end
    end
endmodule

// File: rtl/wpt_table.sv
module wpt_table
    import wpt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int ALIGN_W = 2,
    parameter int NPTR    = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(NPTR + 1),
    localparam int GRP_W  = NPTR * WAY_PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_dir,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_dir,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic [GRP_W-1:0]  wr_ptrs,
    input  logic              inv_req,
    output logic              stall,
    output logic              rsp_valid,
    output logic              rsp_grp_valid,
    output logic [GRP_W-1:0]  rsp_ptrs
);
    logic             flush_en, commit_en, commit_dir, commit_full;
    logic [IDX_W-1:0] commit_idx;
    logic [GRP_W-1:0] commit_ptrs, rd_ptrs;
    logic             rd_valid, take;

    assign take = lk_req && !stall;

    wpt_ctrl #(
        .ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W),
        .NPTR(NPTR), .CNT_W(CNT_W), .GRP_W(GRP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .inv_req(inv_req), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_dir(wr_dir), .wr_count(wr_count),
        .wr_ptrs(wr_ptrs), .stall(stall), .flush_en(flush_en),
        .commit_en(commit_en), .commit_idx(commit_idx),
        .commit_dir(commit_dir), .commit_full(commit_full),
        .commit_ptrs(commit_ptrs)
    );

    wpt_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .GRP_W(GRP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush_en(flush_en), .commit_en(commit_en),
        .commit_idx(commit_idx), .commit_dir(commit_dir),
        .commit_full(commit_full), .commit_ptrs(commit_ptrs),
        .rd_idx(lk_addr[ALIGN_W +: IDX_W]), .rd_dir(lk_dir),
        .rd_valid(rd_valid), .rd_ptrs(rd_ptrs)
    );

    wpt_rsp #(.GRP_W(GRP_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .take(take), .grp_valid(rd_valid),
        .grp_ptrs(rd_ptrs), .rsp_valid(rsp_valid),
        .rsp_grp_valid(rsp_grp_valid), .rsp_ptrs(rsp_ptrs)
    );

    p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !stall) |=> rsp_valid);
    p_no_rsp_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && stall) |=> !rsp_valid);
endmodule

// File: tb/wpt_table_tb.sv
module wpt_table_tb;
    localparam int AW = 32;
    localparam int NP = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_req = 0, lk_dir = 0, wr_req = 0, wr_dir = 0, inv_req = 0;
    logic [AW-1:0] lk_addr = '0, wr_addr = '0;
    logic [2:0] wr_count = '0;
    logic [7:0] wr_ptrs = '0;
    logic stall, rsp_valid, rsp_grp_valid;
    logic [7:0] rsp_ptrs;

    int checks = 0, failures = 0;
    bit done = 0;
    bit       m_vld [16][2];
    logic [7:0] m_ptr [16][2];

    always #4 clk = ~clk;

    wpt_table u_dut (.*);

    function automatic int idx_of(logic [AW-1:0] a);
        return int'(a[5:2]);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic look(logic [AW-1:0] a, bit d, string req);
        int i = idx_of(a);
        lk_req = 1; lk_addr = a; lk_dir = d;
        tick();
        lk_req = 0;
        chk(rsp_valid == 1'b1, req, rsp_valid, 1);
        chk(rsp_grp_valid == m_vld[i][d], req, rsp_grp_valid, m_vld[i][d]);
        if (m_vld[i][d]) chk(rsp_ptrs == m_ptr[i][d], req, rsp_ptrs, m_ptr[i][d]);
    endtask

    task automatic write(logic [AW-1:0] a, bit d, logic [2:0] c, logic [7:0] p,
                         bit poke);
        int i = idx_of(a);
        wr_req = 1; wr_addr = a; wr_dir = d; wr_count = c; wr_ptrs = p;
        tick();
        wr_req = 0;
        // R9: scramble write inputs during the stall cycle
        wr_addr = ~a; wr_dir = ~d; wr_count = 3'd0; wr_ptrs = ~p;
        chk(stall == 1'b1, "R3 stall", stall, 1);
        if (poke) begin lk_req = 1; lk_addr = a ^ 32'h3C; lk_dir = ~d; end
        tick();
        lk_req = 0;
        if (poke) chk(rsp_valid == 1'b0, "R7 no rsp", rsp_valid, 0);
        chk(stall == 1'b0, "R3 stall end", stall, 0);
        m_vld[i][d] = (c == 3'(NP));
        m_ptr[i][d] = p;
    endtask

    task automatic clear(bit with_wr);
        inv_req = 1;
        if (with_wr) begin
            wr_req = 1; wr_addr = 32'h14; wr_dir = 1; wr_count = 3'(NP);
            wr_ptrs = 8'hB4;
        end
        tick();
        inv_req = 0; wr_req = 0;
        chk(stall == 1'b1, "R5 stall", stall, 1);
        tick();
        chk(stall == 1'b0, "R5 stall end", stall, 0);
        foreach (m_vld[i, d]) m_vld[i][d] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        foreach (m_vld[i, d]) begin m_vld[i][d] = 0; m_ptr[i][d] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(stall == 1'b0, "R1 stall", stall, 0);
        chk(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);
        for (int i = 0; i < 16; i++) begin
            look(32'(i << 2), 0, "R1 nt");
            look(32'(i << 2), 1, "R1 tk");
        end
        tick();
        chk(rsp_valid == 1'b0, "R2 idle", rsp_valid, 0);

        write(32'h0000_0008, 1, 3'd4, 8'b11_10_01_00, 1);
        look(32'h0000_0008, 1, "R3 written");
        look(32'h0000_0008, 0, "R8 other dir");
        write(32'h0000_0008, 0, 3'd4, 8'h1B, 0);
        look(32'h0000_0008, 1, "R8 taken kept");
        look(32'h0000_0008, 0, "R8 nt written");
        look(32'hFFF0_0008, 0, "R9 alias");
        write(32'h0000_0010, 1, 3'd3, 8'h6C, 0);
        look(32'h0000_0010, 1, "R4 partial");
        write(32'h0000_0010, 0, 3'd0, 8'h00, 0);
        look(32'h0000_0010, 0, "R4 empty");
        clear(0);
        for (int i = 0; i < 16; i++) look(32'(i << 2), 1, "R5 cleared");
        write(32'h0000_0014, 1, 3'd4, 8'h55, 0);
        clear(1);
        look(32'h0000_0014, 1, "R6 write dropped");

        for (int n = 0; n < 400; n++) begin
            int unsigned r = $urandom % 16;
            logic [AW-1:0] a = $urandom;
            if (r < 8)       look(a, 1'($urandom), "R2 rand");
            else if (r < 15) write(a, 1'($urandom),
                                   ($urandom % 4 == 0) ? 3'($urandom % 4) : 3'd4,
                                   8'($urandom), 1'($urandom));
            else             clear(1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule